// File: doc/BRIEF.md
# Byte Serial Peripheral Interface Controller

This block moves one byte at a time over a four-wire synchronous serial link. Software talks to it through a small register port with two locations. One is a control and status register. The other is a data register that holds the byte to send and, once the exchange ends, the byte received. The block can act as master or as slave, and this is chosen in the control register.

As master, a write to the data register starts the exchange at once. The block makes the serial clock from the system clock, using a source select (full or half system rate) and a rate divisor (1, 4 or 16). As slave, it shifts on an externally supplied clock. It brings that clock into its own clock domain through a synchroniser. When select gating is enabled, the active-low select input qualifies the shifting.

Clock polarity is idle-low. Data out changes after a falling edge, and data in is sampled on a rising edge. A completion flag and a write-collision flag are set by hardware and cleared by software. The completion flag also drives an interrupt request. Tristate pins are modelled as a data output plus an output enable.

Top module: `spi_xcvr`

## Requirements
- R1: After reset the control register (address 0) reads 0x60, all three output enables are low and `irq` is low.
- R2: Control bits 7..2 are written and read back unchanged. Bit 7 is source select, bits 6:5 are the mode, bit 4 is enable, bit 3 is MSB-first, bit 2 is select enable. Writing 0 to bit 1 clears the collision flag, and writing 0 to bit 0 clears the done flag. Writing 1 to either flag bit leaves it unchanged.
- R3: With enable (bit 4) at 0, `sck_oe`, `sdo_oe` and `ss_n_oe` are all 0. With enable at 1 in a master mode and no exchange running, the serial clock and data out are driven low. `ss_n_oe` equals the select-enable bit and `ss_n_o` is 0.
- R4: In master mode one half-period of the serial clock lasts N system cycles. N = S*D, where S is 1 when bit 7 is 1 and 2 when bit 7 is 0, and D is 1, 4 or 16 for mode 00, 01 or 10. The done flag reads 1 exactly 16*N cycles after the clock edge that captures the data-register write, and reads 0 one cycle earlier.
- R5: With bit 3 at 1, bit 7 is sent and received first. With bit 3 at 0, bit 0 goes first. Data out is stable at each rising serial-clock edge, and data in is taken on that rising edge.
- R6: At the end of 8 bits the received byte replaces the data register (address 1), the done flag (bit 0) is set and `irq` equals the done flag.
- R7: A data-register write while an exchange is running leaves the data register and the running exchange unchanged, and sets the collision flag (bit 1).
- R8: In slave mode (mode 11) the block shifts on the external clock with the same edge and bit-order rules. With select enable at 1, edges while `ss_n_i` is high cause no shifting and no completion. With select enable at 0, the clock alone drives the exchange.
- R9: The data register keeps its contents through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| sck_i | input | 1 | Serial clock input (slave mode) |
| sck_o | output | 1 | Serial clock output (master mode) |
| sck_oe | output | 1 | Serial clock output enable |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output |
| sdo_oe | output | 1 | Serial data output enable |
| ss_n_i | input | 1 | Active-low select input (slave mode) |
| ss_n_o | output | 1 | Active-low select output |
| ss_n_oe | output | 1 | Select output enable |
| irq | output | 1 | Completion interrupt request |

## Verification
The bench uses the default parameters: a mid divisor of 4, a slow divisor of 16 and two synchroniser stages. At these values the slowest half-period is 32 cycles and a whole master byte takes at most 512 cycles. This keeps every source-select and divisor pair, each with exact completion timing, within reach of a short random run. The two-stage synchroniser lets the bench's slave clock, at a half-period of 8 system cycles, meet the quarter-rate limit with margin.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_FAST  = 2'b00,
    MODE_MID   = 2'b01,
    MODE_SLOW  = 2'b10,
    MODE_SLAVE = 2'b11
  } mode_e;

  typedef struct packed {
    logic  src_full;
    mode_e mode;
    logic  enable;
    logic  msb_first;
    logic  sel_en;
    logic  wcol;
    logic  done;
  } ctrl_t;

  localparam logic [7:0] CTRL_RESET = 8'h60;

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_xcvr_pkg::*;
#(
  parameter int RATE_MID  = 4,
  parameter int RATE_SLOW = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  logic  src_full,
  input  mode_e mode,
  output logic  tick
);

  localparam int CW = $clog2(2 * RATE_SLOW) + 1;

  logic [CW-1:0] base;
  logic [CW-1:0] half;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    case (mode)
      MODE_FAST: base = CW'(1);
      MODE_MID:  base = CW'(RATE_MID);
      default:   base = CW'(RATE_SLOW);
    endcase
    half = src_full ? base : (base << 1);
  end

  assign tick = run && (cnt_q == (half - CW'(1)));

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic ss_n_i,
  input  logic sdi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic ss_n_s,
  output logic sdi_s
);

  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] RST_VAL = 3'b010;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            sck_prev_q;

  assign raw = {sdi_i, ss_n_i, sck_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_chain
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= {STAGES{RST_VAL[g]}};
      else        sh_q <= {sh_q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev_q <= 1'b0;
    else        sck_prev_q <= synced[0];
  end

  assign sck_rise = synced[0] && !sck_prev_q;
  assign sck_fall = !synced[0] && sck_prev_q;
  assign ss_n_s   = synced[1];
  assign sdi_s    = synced[2];

endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              msb_first,
  input  logic              sample_en,
  input  logic              shift_en,
  input  logic              sdi_bit,
  output logic              tx_bit,
  output logic              last,
  output logic [DATA_W-1:0] rx_word
);

  localparam int CW = $clog2(DATA_W);

  logic [DATA_W-1:0] sr_q, sr_d, sr_shift;
  logic              samp_q, samp_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  assign sr_shift = msb_first ? {sr_q[DATA_W-2:0], samp_q}
                              : {samp_q, sr_q[DATA_W-1:1]};
  assign tx_bit   = msb_first ? sr_q[DATA_W-1] : sr_q[0];
  assign last     = (cnt_q == CW'(DATA_W - 1));
  assign rx_word  = sr_shift;

  always_comb begin
    sr_d   = sr_q;
    samp_d = samp_q;
    cnt_d  = cnt_q;
    if (load)          sr_d = load_val;
    else if (shift_en) sr_d = sr_shift;
    if (sample_en)     samp_d = sdi_bit;
    if (clr || load)   cnt_d = '0;
    else if (shift_en) cnt_d = last ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      samp_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sr_q   <= sr_d;
      samp_q <= samp_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_xcvr_pkg::*;
#(
  parameter int RATE_MID    = 4,
  parameter int RATE_SLOW   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe,
  input  logic              ss_n_i,
  output logic              ss_n_o,
  output logic              ss_n_oe,
  output logic              irq
);

  ctrl_t             ctrl_q, ctrl_d;
  logic [BYTE_W-1:0] dat_q, dat_d;
  logic              busy_q, busy_d;
  logic              sck_q, sck_d;

  logic is_master, en;
  logic wr_ctrl, wr_data, collide, load, start_m;
  logic tick, rise_m, fall_m;
  logic s_rise, s_fall, ss_n_s, sdi_s, s_act, rise_s, fall_s;
  logic sample_en, shift_en, sdi_bit, tx_bit, last, done;
  logic [BYTE_W-1:0] rx_word;

  assign en        = ctrl_q.enable;
  assign is_master = (ctrl_q.mode != MODE_SLAVE);
  assign wr_ctrl   = reg_wr && !reg_addr;
  assign wr_data   = reg_wr && reg_addr;
  assign collide   = wr_data && busy_q;
  assign load      = wr_data && !busy_q;
  assign start_m   = load && en && is_master;

  spi_rate_gen #(
    .RATE_MID  (RATE_MID),
    .RATE_SLOW (RATE_SLOW)
  ) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy_q && en && is_master),
    .src_full (ctrl_q.src_full),
    .mode     (ctrl_q.mode),
    .tick     (tick)
  );

  assign rise_m = tick && !sck_q;
  assign fall_m = tick && sck_q;

  spi_sync_edge #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_i    (sck_i),
    .ss_n_i   (ss_n_i),
    .sdi_i    (sdi_i),
    .sck_rise (s_rise),
    .sck_fall (s_fall),
    .ss_n_s   (ss_n_s),
    .sdi_s    (sdi_s)
  );

  assign s_act  = en && !is_master && (!ctrl_q.sel_en || !ss_n_s);
  assign rise_s = s_rise && s_act;
  assign fall_s = s_fall && s_act;

  assign sample_en = is_master ? rise_m : rise_s;
  assign shift_en  = is_master ? fall_m : fall_s;
  assign sdi_bit   = is_master ? sdi_i  : sdi_s;

  spi_shift #(
    .DATA_W (BYTE_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!en),
    .load      (load),
    .load_val  (reg_wdata),
    .msb_first (ctrl_q.msb_first),
    .sample_en (sample_en),
    .shift_en  (shift_en),
    .sdi_bit   (sdi_bit),
    .tx_bit    (tx_bit),
    .last      (last),
    .rx_word   (rx_word)
  );

  assign done = shift_en && last;

  // Busy and serial-clock next state
  always_comb begin
    busy_d = busy_q;
    if (!en)                          busy_d = 1'b0;
    else if (done)                    busy_d = 1'b0;
    else if (start_m)                 busy_d = 1'b1;
    else if (!is_master && rise_s)    busy_d = 1'b1;

    if (!busy_d)   sck_d = 1'b0;
    else if (tick) sck_d = !sck_q;
    else           sck_d = sck_q;
  end

  // Control register next state; hardware sets win over software clears
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.src_full  = reg_wdata[7];
      ctrl_d.mode      = mode_e'(reg_wdata[6:5]);
      ctrl_d.enable    = reg_wdata[4];
      ctrl_d.msb_first = reg_wdata[3];
      ctrl_d.sel_en    = reg_wdata[2];
      ctrl_d.wcol      = ctrl_q.wcol && reg_wdata[1];
      ctrl_d.done      = ctrl_q.done && reg_wdata[0];
    end
    if (collide) ctrl_d.wcol = 1'b1;
    if (done)    ctrl_d.done = 1'b1;
  end

  always_comb begin
    dat_d = dat_q;
    if (load)      dat_d = reg_wdata;
    else if (done) dat_d = rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= ctrl_t'(CTRL_RESET);
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      busy_q <= busy_d;
      sck_q  <= sck_d;
    end
  end

  // Data register keeps its value through reset
  always_ff @(posedge clk) begin
    dat_q <= dat_d;
  end

  assign reg_rdata = reg_addr ? dat_q : ctrl_q;

  assign sck_o   = sck_q;
  assign sck_oe  = en && is_master;
  assign sdo_o   = is_master ? (busy_q && tx_bit) : tx_bit;
  assign sdo_oe  = en;
  assign ss_n_o  = 1'b0;
  assign ss_n_oe = en && is_master && ctrl_q.sel_en;
  assign irq     = ctrl_q.done;

endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic [7:0] ctrl,
  input logic [7:0] dat,
  input logic       reg_wr,
  input logic       reg_addr,
  input logic [7:0] reg_wdata,
  input logic       sck_o,
  input logic       sck_oe,
  input logic       sdo_oe,
  input logic       ss_n_oe
);

  p_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[4] |-> (!sck_oe && !sdo_oe && !ss_n_oe));

  p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[4] && ctrl[6:5] != 2'b11 && !busy) |-> (sck_oe && !sck_o));

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !(reg_wr && !reg_addr && !reg_wdata[0])) |=> ctrl[0]);

  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl[0]) |-> $past(busy));

  p_wcol_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[1] && !(reg_wr && !reg_addr && !reg_wdata[1])) |=> ctrl[1]);

  p_collide_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr && !done) |=> ($stable(dat) && ctrl[1]));

endmodule

bind spi_xcvr spi_xcvr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy_q),
  .done      (done),
  .ctrl      (ctrl_q),
  .dat       (dat_q),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .sck_o     (sck_o),
  .sck_oe    (sck_oe),
  .sdo_oe    (sdo_oe),
  .ss_n_oe   (ss_n_oe)
);

// File: tb/spi_xcvr_bench.sv
module spi_xcvr_bench;

  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic       reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       sck_i, sck_o, sck_oe;
  logic       sdi_i, sdo_o, sdo_oe;
  logic       ss_n_i, ss_n_o, ss_n_oe;
  logic       irq;

  int n_chk;
  int n_bad;

  logic       slv;
  logic       s_sdi;
  logic [7:0] m_in;
  bit         msb_g;
  int         midx;
  int         cidx;
  logic [7:0] cap;

  spi_xcvr u_spi_xcvr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .ss_n_i(ss_n_i), .ss_n_o(ss_n_o), .ss_n_oe(ss_n_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic bit_at(logic [7:0] d, bit msb, int k);
    return msb ? d[7-k] : d[k];
  endfunction

  function automatic logic [7:0] seq_of(logic [7:0] d, bit msb);
    logic [7:0] s;
    for (int k = 0; k < 8; k++) s[k] = bit_at(d, msb, k);
    return s;
  endfunction

  function automatic logic [7:0] cfg(bit cks, bit [1:0] md, bit en, bit msb, bit cs);
    return {cks, md, en, msb, cs, 2'b00};
  endfunction

  function automatic int half_n(bit cks, bit [1:0] md);
    int d;
    d = (md == 2'b00) ? 1 : (md == 2'b01) ? 4 : 16;
    return (cks ? 1 : 2) * d;
  endfunction

  assign sdi_i = slv ? s_sdi : bit_at(m_in, msb_g, (midx > 7) ? 7 : midx);

  always @(posedge sck_o) begin
    if (!slv && cidx < 8) begin
      cap[cidx] = sdo_o;
      cidx++;
    end
  end

  always @(negedge sck_o) midx++;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_irq(output int k);
    k = 0;
    while (!irq && k < 5000) begin
      @(posedge clk);
      k++;
      @(negedge clk);
    end
  endtask

  task automatic master_xfer(bit cks, bit [1:0] md, bit msb, bit cs,
                             logic [7:0] tx, logic [7:0] pat);
    logic [7:0] c, d;
    int k;
    slv = 1'b0;
    wr(1'b0, cfg(cks, md, 1'b1, msb, cs));
    rd(1'b0, c);
    check("R2 control readback", c, cfg(cks, md, 1'b1, msb, cs));
    check("R3 idle sck/sdo driven low", {sck_oe, sck_o, sdo_oe, sdo_o}, 4'b1010);
    check("R3 select enable", {ss_n_oe, ss_n_o}, {cs, 1'b0});
    m_in  = pat;
    msb_g = msb;
    midx  = 0;
    cidx  = 0;
    wr(1'b1, tx);
    wait_irq(k);
    check("R4 completion cycles", k, 16 * half_n(cks, md));
    check("R5 sdo bit order", cap, seq_of(tx, msb));
    rd(1'b1, d);
    check("R6 received byte", d, pat);
    check("R6 irq on done", irq, 1'b1);
    wr(1'b0, cfg(cks, md, 1'b1, msb, cs));
    check("R2 done cleared by 0", irq, 1'b0);
  endtask

  task automatic slave_byte(logic [7:0] pat, bit msb, output logic [7:0] seq);
    for (int k = 0; k < 8; k++) begin
      s_sdi = bit_at(pat, msb, k);
      repeat (8) @(negedge clk);
      seq[k] = sdo_o;
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] c, d, s;
    int k;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    sck_i = 1'b0; ss_n_i = 1'b1; s_sdi = 1'b0; slv = 1'b0;
    m_in = '0; msb_g = 1'b1; midx = 0; cidx = 0; cap = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1'b0, c);
    check("R1 control reset value", c, 8'h60);
    check("R1 enables and irq", {sck_oe, sdo_oe, ss_n_oe, irq}, 4'b0000);

    // R9 data survives reset; R3 disabled releases pins
    wr(1'b1, 8'hA5);
    check("R3 released when disabled", {sck_oe, sdo_oe, ss_n_oe}, 3'b000);
    do_reset();
    rd(1'b1, d);
    check("R9 data kept through reset", d, 8'hA5);

    // Directed corner cases: fastest and slowest rates, both orders
    master_xfer(1'b1, 2'b00, 1'b1, 1'b1, 8'h96, 8'h3C);
    master_xfer(1'b0, 2'b10, 1'b0, 1'b0, 8'h01, 8'h80);
    master_xfer(1'b0, 2'b00, 1'b0, 1'b1, 8'hFF, 8'h00);

    // Random master exchanges
    for (int i = 0; i < 10; i++) begin
      master_xfer(1'($urandom % 2), 2'($urandom % 3), 1'($urandom % 2),
                  1'($urandom % 2), 8'($urandom), 8'($urandom));
    end

    // R7 collision during slow transfer
    slv = 1'b0;
    wr(1'b0, cfg(1'b0, 2'b10, 1'b1, 1'b1, 1'b0));
    m_in = 8'h5A; msb_g = 1'b1; midx = 0; cidx = 0;
    wr(1'b1, 8'hC3);
    repeat (40) @(negedge clk);
    wr(1'b1, 8'hFF);
    rd(1'b0, c);
    check("R7 wcol set on busy write", c[1], 1'b1);
    wait_irq(k);
    rd(1'b1, d);
    check("R7 busy write ignored", d, 8'h5A);
    check("R7 tx unaffected", cap, seq_of(8'hC3, 1'b1));
    wr(1'b0, cfg(1'b0, 2'b10, 1'b1, 1'b1, 1'b0) | 8'h03);
    rd(1'b0, c);
    check("R2 writing 1 keeps flags", c[1:0], 2'b11);
    wr(1'b0, cfg(1'b0, 2'b10, 1'b1, 1'b1, 1'b0) | 8'h01);
    rd(1'b0, c);
    check("R2 wcol cleared alone", c[1:0], 2'b01);
    wr(1'b0, cfg(1'b0, 2'b10, 1'b1, 1'b1, 1'b0));
    rd(1'b0, c);
    check("R2 done cleared", c[1:0], 2'b00);

    // R8 slave, select gating on, select high: nothing happens
    slv = 1'b1;
    wr(1'b0, cfg(1'b0, 2'b11, 1'b1, 1'b1, 1'b1));
    check("R8 slave pin enables", {sck_oe, sdo_oe, ss_n_oe}, 3'b010);
    wr(1'b1, 8'h3C);
    ss_n_i = 1'b1;
    slave_byte(8'hE7, 1'b1, s);
    rd(1'b1, d);
    check("R8 gated: data unchanged", d, 8'h3C);
    check("R8 gated: no done", irq, 1'b0);

    // R8 select low: exchange proceeds
    ss_n_i = 1'b0;
    slave_byte(8'hE7, 1'b1, s);
    check("R8 slave sdo order msb", s, seq_of(8'h3C, 1'b1));
    rd(1'b1, d);
    check("R8 slave received", d, 8'hE7);
    check("R8 slave done", irq, 1'b1);

    // R8 select gating off, select high, LSB first
    ss_n_i = 1'b1;
    wr(1'b0, cfg(1'b1, 2'b11, 1'b1, 1'b0, 1'b0));
    wr(1'b1, 8'h71);
    slave_byte(8'h2B, 1'b0, s);
    check("R8 ungated sdo order lsb", s, seq_of(8'h71, 1'b0));
    rd(1'b1, d);
    check("R8 ungated received", d, 8'h2B);
    check("R8 ungated done", irq, 1'b1);

    report();
  end

endmodule